// File: doc/BRIEF.md
# Segment Access Protection Checker

This block decides whether one memory access may go ahead against a segment descriptor already held in the pipeline. It takes the descriptor's base, limit, present bit, privilege fields and type bits, the current privilege level, the protected-mode enable and the access itself: offset, byte count and kind (instruction fetch, data read or data write). It returns either a grant with the linear address or a fault, classed as general protection or segment-not-present.

The check is combinational between two registers of a simple valid/ready handshake. A request is taken when `req_valid` and `req_ready` are both high. The verdict appears on the response port one cycle later and stays there until the consumer raises `rsp_ready`. Loading descriptors, translating pages and performing the access belong to other blocks.

Top module: `seg_access_checker`

## Requirements
- R1: The access covers bytes `req_offset` to `req_offset + req_size - 1`, with the sum formed one bit wider than the address. If that last byte is above `seg_limit`, the result is a general-protection fault, whether `pe_en` is high or low. An end that wraps past the top of the address space therefore faults.
- R2: With `pe_en` low, an access inside the limit is granted whatever the present, privilege and type fields hold.
- R3: With `pe_en` high and `seg_present` low, an access inside the limit gives a segment-not-present fault.
- R4: With `pe_en` high, `cur_pl` numerically greater than `seg_dpl` gives a general-protection fault. For reads and writes, `seg_rpl` greater than `seg_dpl` also faults. Instruction fetches ignore `seg_rpl`.
- R5: An instruction fetch from a segment with `seg_exec` low gives a general-protection fault in protected mode.
- R6: A data read from a segment with `seg_exec` high and `seg_rw` low gives a general-protection fault. Reads from non-executable segments do not depend on `seg_rw`.
- R7: A write to a segment with `seg_exec` high gives a general-protection fault. So does a write to a segment with `seg_exec` low and `seg_rw` low.
- R8: The checks run in a fixed order: limit, then present, then privilege, then type. Only the first failing check is reported. `rsp_fault` encodes 2'b00 as none, 2'b01 as general protection and 2'b10 as segment-not-present.
- R9: `rsp_grant` is high exactly when `rsp_fault` is 2'b00. On a grant, `rsp_lin_addr` is `seg_base + req_offset` modulo 2^ADDR_W. On a fault it is zero.
- R10: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted request gives `rsp_valid` high on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, every response output holds its value. After reset, `rsp_valid` is low.
- R11: `req_kind` encodes 2'b00 as instruction fetch, 2'b01 as data read and 2'b10 as data write. The code 2'b11 is checked as a data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 2 | Access kind (R11) |
| req_offset | input | ADDR_W | Offset within the segment |
| req_size | input | SIZE_W | Access length in bytes (at least 1) |
| pe_en | input | 1 | Protected-mode enable |
| cur_pl | input | PL_W | Current privilege level |
| seg_base | input | ADDR_W | Descriptor base |
| seg_limit | input | ADDR_W | Descriptor limit (last valid offset) |
| seg_present | input | 1 | Descriptor present bit |
| seg_dpl | input | PL_W | Descriptor privilege level |
| seg_rpl | input | PL_W | Requested privilege level of the selector |
| seg_exec | input | 1 | Segment is code |
| seg_rw | input | 1 | Readable (code) or writable (data) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 2 | Fault class (R8) |
| rsp_lin_addr | output | ADDR_W | Linear address on grant, zero on fault |

## Verification
The bound assertions check the handshake rules on every cycle: ready, the one-cycle response and holding under back-pressure. They also check that grant and fault class agree, that a faulted response carries a zero address, that a limit overrun always yields general protection, and that real mode never reports segment-not-present. Only the bench scenarios can show the full privilege and type matrix, the exact fault chosen when several checks fail at once, and the values of wrapped linear addresses and boundary offsets. The bench sweeps every combination of mode, present bit, type bits, kind and the three privilege levels, and compares each result with a model built from the requirements.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

   typedef enum logic [1:0] {
      KIND_FETCH = 2'b00,
      KIND_READ  = 2'b01,
      KIND_WRITE = 2'b10,
      KIND_WRALT = 2'b11
   } acc_kind_e;

   typedef enum logic [1:0] {
      FLT_NONE = 2'b00,
      FLT_GP   = 2'b01,
      FLT_NP   = 2'b10
   } fault_e;

endpackage

// File: rtl/seg_limit_check.sv
// Bound test: last byte of the access against the segment limit, one bit wide
module seg_limit_check #(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 3
) (
   input  logic [ADDR_W-1:0] offset,
   input  logic [SIZE_W-1:0] size,
   input  logic [ADDR_W-1:0] limit,
   output logic              over
);
   localparam int WIDE_W = ADDR_W + 1;

   logic [WIDE_W-1:0] last_byte;
   logic [WIDE_W-1:0] wide_size;
   logic [WIDE_W-1:0] wide_limit;

   assign wide_size  = {{(WIDE_W-SIZE_W){1'b0}}, size};
   assign wide_limit = {1'b0, limit};

   always_comb begin
      last_byte = {1'b0, offset} + wide_size - WIDE_W'(1);
      over      = (last_byte > wide_limit);
   end
endmodule

// File: rtl/seg_rights_check.sv
// Present, privilege and type rules; only active in protected mode
module seg_rights_check
   import seg_chk_pkg::*;
#(
   parameter int PL_W = 2
) (
   input  logic            pe_en,
   input  acc_kind_e       kind,
   input  logic [PL_W-1:0] cpl,
   input  logic [PL_W-1:0] dpl,
   input  logic [PL_W-1:0] rpl,
   input  logic            present,
   input  logic            exec,
   input  logic            rw,
   output logic            np_fault,
   output logic            gp_fault
);
   logic is_fetch;
   logic is_read;
   logic is_write;
   logic priv_bad;
   logic type_bad;

   always_comb begin
      is_fetch = (kind == KIND_FETCH);
      is_read  = (kind == KIND_READ);
      is_write = (kind == KIND_WRITE) || (kind == KIND_WRALT);

      priv_bad = (cpl > dpl) || (!is_fetch && (rpl > dpl));

      type_bad = 1'b0;
      if (is_fetch)      type_bad = !exec;
      else if (is_read)  type_bad = exec && !rw;
      else if (is_write) type_bad = exec || !rw;

      np_fault = pe_en && !present;
      gp_fault = pe_en && present && (priv_bad || type_bad);
   end
endmodule

// File: rtl/seg_access_checker.sv
module seg_access_checker
   import seg_chk_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 3,
   parameter int PL_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_offset,
   input  logic [SIZE_W-1:0] req_size,
   input  logic              pe_en,
   input  logic [PL_W-1:0]   cur_pl,
   input  logic [ADDR_W-1:0] seg_base,
   input  logic [ADDR_W-1:0] seg_limit,
   input  logic              seg_present,
   input  logic [PL_W-1:0]   seg_dpl,
   input  logic [PL_W-1:0]   seg_rpl,
   input  logic              seg_exec,
   input  logic              seg_rw,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic              rsp_grant,
   output logic [1:0]        rsp_fault,
   output logic [ADDR_W-1:0] rsp_lin_addr
);
   localparam logic [ADDR_W-1:0] ZERO_ADDR = '0;

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("seg_access_checker: ADDR_W must be at least 8");
      end
      if (SIZE_W < 1 || SIZE_W > ADDR_W) begin : g_bad_size
         $error("seg_access_checker: SIZE_W must lie in 1..ADDR_W");
      end
      if (PL_W < 1) begin : g_bad_pl
         $error("seg_access_checker: PL_W must be at least 1");
      end
   endgenerate

   logic        lim_over;
   logic        np_fault;
   logic        gp_fault;
   fault_e      verdict;
   logic [ADDR_W-1:0] lin_sum;
   logic        take;

   seg_limit_check #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_limit (
      .offset (req_offset),
      .size   (req_size),
      .limit  (seg_limit),
      .over   (lim_over)
   );

   seg_rights_check #(.PL_W(PL_W)) u_rights (
      .pe_en    (pe_en),
      .kind     (acc_kind_e'(req_kind)),
      .cpl      (cur_pl),
      .dpl      (seg_dpl),
      .rpl      (seg_rpl),
      .present  (seg_present),
      .exec     (seg_exec),
      .rw       (seg_rw),
      .np_fault (np_fault),
      .gp_fault (gp_fault)
   );

   // Fixed priority: limit, present, privilege/type
   always_comb begin
      if (lim_over)      verdict = FLT_GP;
      else if (np_fault) verdict = FLT_NP;
      else if (gp_fault) verdict = FLT_GP;
      else               verdict = FLT_NONE;
      lin_sum = seg_base + req_offset;
   end

   assign req_ready = !rsp_valid || rsp_ready;
   assign take      = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_grant    <= 1'b0;
         rsp_fault    <= FLT_NONE;
         rsp_lin_addr <= ZERO_ADDR;
      end else if (take) begin
         rsp_valid    <= 1'b1;
         rsp_grant    <= (verdict == FLT_NONE);
         rsp_fault    <= verdict;
         rsp_lin_addr <= (verdict == FLT_NONE) ? lin_sum : ZERO_ADDR;
      end else if (rsp_ready) begin
         rsp_valid    <= 1'b0;
      end
   end
endmodule

// File: rtl/seg_access_checker_sva.sv
module seg_access_checker_sva #(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_offset,
   input logic [SIZE_W-1:0] req_size,
   input logic [ADDR_W-1:0] seg_limit,
   input logic              pe_en,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic              rsp_grant,
   input logic [1:0]        rsp_fault,
   input logic [ADDR_W-1:0] rsp_lin_addr
);
   logic        accept;
   logic [ADDR_W:0] end_chk;
   assign accept  = req_valid && req_ready;
   assign end_chk = {1'b0, req_offset} + {{(ADDR_W+1-SIZE_W){1'b0}}, req_size} - 1'b1;

   a_r10_accept_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> rsp_valid);

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_grant)
                                     && $stable(rsp_fault) && $stable(rsp_lin_addr)));

   a_r10_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |-> !req_ready);

   a_r9_grant_fault: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_grant == (rsp_fault == 2'b00)));

   a_r9_fault_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_grant) |-> (rsp_lin_addr == '0));

   a_r1_limit_gp: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (end_chk > {1'b0, seg_limit})) |=> (rsp_fault == 2'b01));

   a_r3_np_needs_pe: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !pe_en) |=> (rsp_fault != 2'b10));

   a_r8_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_fault != 2'b11));
endmodule

bind seg_access_checker seg_access_checker_sva #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .req_offset   (req_offset),
   .req_size     (req_size),
   .seg_limit    (seg_limit),
   .pe_en        (pe_en),
   .rsp_valid    (rsp_valid),
   .rsp_ready    (rsp_ready),
   .rsp_grant    (rsp_grant),
   .rsp_fault    (rsp_fault),
   .rsp_lin_addr (rsp_lin_addr)
);

// File: tb/seg_access_checker_tb_top.sv
`timescale 1ns/1ps
module seg_access_checker_tb_top;
   localparam int AW = 32;
   localparam int SW = 3;
   localparam int PW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_kind = 2'b00;
   logic [AW-1:0] req_offset = '0;
   logic [SW-1:0] req_size = 3'd1;
   logic          pe_en = 1'b0;
   logic [PW-1:0] cur_pl = '0;
   logic [AW-1:0] seg_base = '0;
   logic [AW-1:0] seg_limit = '0;
   logic          seg_present = 1'b0;
   logic [PW-1:0] seg_dpl = '0;
   logic [PW-1:0] seg_rpl = '0;
   logic          seg_exec = 1'b0;
   logic          seg_rw = 1'b0;
   logic          rsp_valid;
   logic          rsp_ready = 1'b1;
   logic          rsp_grant;
   logic [1:0]    rsp_fault;
   logic [AW-1:0] rsp_lin_addr;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   seg_access_checker #(.ADDR_W(AW), .SIZE_W(SW), .PL_W(PW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_offset(req_offset), .req_size(req_size),
      .pe_en(pe_en), .cur_pl(cur_pl), .seg_base(seg_base), .seg_limit(seg_limit),
      .seg_present(seg_present), .seg_dpl(seg_dpl), .seg_rpl(seg_rpl),
      .seg_exec(seg_exec), .seg_rw(seg_rw), .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault),
      .rsp_lin_addr(rsp_lin_addr)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   // Reference model written from the requirements
   function automatic logic [1:0] model_fault(output string tag);
      longint last_b;
      bit     fetch, rd, wr;
      last_b = longint'(req_offset) + longint'(req_size) - 1;
      fetch  = (req_kind == 2'b00);
      rd     = (req_kind == 2'b01);
      wr     = req_kind[1];
      if (last_b > longint'(seg_limit)) begin tag = "R1"; return 2'b01; end
      if (!pe_en)                       begin tag = "R2"; return 2'b00; end
      if (!seg_present)                 begin tag = "R3"; return 2'b10; end
      if (cur_pl > seg_dpl)             begin tag = "R4"; return 2'b01; end
      if (!fetch && seg_rpl > seg_dpl)  begin tag = "R4"; return 2'b01; end
      if (fetch && !seg_exec)           begin tag = "R5"; return 2'b01; end
      if (rd && seg_exec && !seg_rw)    begin tag = "R6"; return 2'b01; end
      if (wr && (seg_exec || !seg_rw))  begin tag = "R7"; return 2'b01; end
      tag = wr ? "R11" : "R9";
      return 2'b00;
   endfunction

   // Issue one request at a falling edge, sample its response one cycle on
   task automatic run_one(input string extra);
      string         tag;
      logic [1:0]    ef;
      logic [AW-1:0] ea;
      @(negedge clk);
      req_valid = 1'b1;
      ef = model_fault(tag);
      ea = (ef == 2'b00) ? seg_base + req_offset : '0;
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid == 1'b1, "R10", {extra, " rsp_valid"}, rsp_valid, 1);
      check(rsp_fault == ef, tag, {extra, " fault"}, rsp_fault, ef);
      check(rsp_grant == (ef == 2'b00), "R9", {extra, " grant"}, rsp_grant, ef == 2'b00);
      check(rsp_lin_addr == ea, "R9", {extra, " lin_addr"}, rsp_lin_addr, ea);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(rsp_valid == 1'b0, "R10", "reset rsp_valid", rsp_valid, 0);
      check(req_ready == 1'b1, "R10", "reset req_ready", req_ready, 1);
      rst_n = 1'b1;

      // Exhaustive sweep of mode, flags, kind and privilege levels (R2..R7, R11)
      seg_base  = 32'h0001_0000;
      seg_limit = 32'h0000_0FFF;
      req_offset = 32'h0000_0100;
      req_size  = 3'd4;
      for (int pe = 0; pe < 2; pe++)
         for (int pr = 0; pr < 2; pr++)
            for (int ex = 0; ex < 2; ex++)
               for (int rw = 0; rw < 2; rw++)
                  for (int k = 0; k < 4; k++)
                     for (int pl = 0; pl < 64; pl++) begin
                        pe_en = pe[0]; seg_present = pr[0];
                        seg_exec = ex[0]; seg_rw = rw[0];
                        req_kind = k[1:0];
                        cur_pl = pl[1:0]; seg_dpl = pl[3:2]; seg_rpl = pl[5:4];
                        run_one("sweep");
                     end

      // Limit boundaries in both modes (R1)
      pe_en = 1'b1; seg_present = 1'b1; seg_exec = 1'b0; seg_rw = 1'b1;
      cur_pl = 0; seg_dpl = 0; seg_rpl = 0; req_kind = 2'b01;
      for (int m = 0; m < 2; m++)
         for (int s = 1; s <= 4; s++) begin
            pe_en = m[0];
            req_size = SW'(s);
            seg_limit = 32'h0000_00FF;
            req_offset = 32'h100 - 32'(s);        run_one("R1 last byte at limit");
            req_offset = 32'h100 - 32'(s) + 1;    run_one("R1 one past limit");
         end
      // Wrap past the top of the address space (R1)
      seg_limit = 32'hFFFF_FFFF; req_size = 3'd4;
      req_offset = 32'hFFFF_FFFC; run_one("R1 top fits");
      req_offset = 32'hFFFF_FFFE; run_one("R1 wrap");
      check(rsp_fault == 2'b01, "R1", "wrap is GP", rsp_fault, 1);

      // Priority: limit over not-present, not-present over privilege/type (R8)
      pe_en = 1'b1; seg_present = 1'b0; seg_limit = 32'h10;
      req_offset = 32'h20; req_size = 3'd1;
      run_one("R8 limit beats NP");
      check(rsp_fault == 2'b01, "R8", "limit first", rsp_fault, 1);
      req_offset = 32'h4; cur_pl = 2'd3; seg_dpl = 2'd0; seg_exec = 1'b1;
      seg_rw = 1'b0; req_kind = 2'b10;
      run_one("R8 NP beats GP");
      check(rsp_fault == 2'b10, "R8", "present before privilege", rsp_fault, 2);

      // Linear address wraps modulo 2^32 (R9)
      seg_present = 1'b1; cur_pl = 0; seg_exec = 1'b0; seg_rw = 1'b1;
      req_kind = 2'b01; seg_limit = 32'hFFFF_FFFF;
      seg_base = 32'hFFFF_FFF0; req_offset = 32'h20;
      run_one("R9 base wrap");
      check(rsp_lin_addr == 32'h10, "R9", "wrapped address", rsp_lin_addr, 32'h10);

      // Back-pressure: response held, new request not taken (R10)
      seg_base = 32'h100; req_offset = 32'h8;
      @(negedge clk);
      req_valid = 1'b1; rsp_ready = 1'b0;
      @(negedge clk);
      req_offset = 32'h40;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(req_ready == 1'b0, "R10", "stall ready low", req_ready, 0);
         check(rsp_valid == 1'b1, "R10", "stall valid held", rsp_valid, 1);
         check(rsp_lin_addr == 32'h108, "R10", "stall data held", rsp_lin_addr, 32'h108);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_lin_addr == 32'h140, "R10", "queued request served", rsp_lin_addr, 32'h140);
      @(negedge clk);
      check(rsp_valid == 1'b0, "R10", "idle after drain", rsp_valid, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule